// File: doc/BRIEF.md
# Per-Queue Receive Frame Policer

This block enforces a receive bandwidth allocation on each of several host queues that belong to virtual machines. It sits between the stage that maps an incoming frame to its queue and the queues themselves. Each queue owns an independent byte-based token bucket. When the first beat of a frame arrives, the bucket of the target queue is compared with the frame length given on that beat. If the bucket covers the frame, the frame is forwarded and its length is charged. If it does not, every beat of the frame is discarded, so excess traffic never reaches the host and raises no interrupt there.

A shared tick fires every `TICK_PERIOD` clock cycles. On each tick every bucket gains its own programmable fill amount, capped at its own programmable depth. Software can enable, disable and retune each queue at run time through a small register port, and can read each bucket's level and its passed and dropped frame counts. A disabled queue forwards everything.

Top module: `rx_queue_policer`

## Requirements
- R1: After reset every register of every queue reads 0, and `outValid` is low.
- R2: A queue whose enable bit (field 0, bit 0) is 0 forwards every beat of every frame, with one cycle of latency, and its bucket level is not charged.
- R3: A bucket level never exceeds that queue's depth (field 2); refill stops at the depth.
- R4: On an enabled queue, a frame is admitted exactly when the level is at least the length on its first beat (`inSof` high). An admitted frame lowers the level by its length, and its beats come out one cycle later with data, flags and queue unchanged.
- R5: On an enabled queue, a frame that is not covered is dropped whole: none of its beats reach the output, and the level is left untouched.
- R6: Every `TICK_PERIOD` cycles each bucket gains its fill amount (field 1). Over any window of m times `TICK_PERIOD` cycles with a fixed fill f, the level rises by m times f, up to the depth.
- R7: A depth write clamps the level to the new depth on the clock edge of that write. Raising the depth adds no tokens. A new fill amount is applied from the next tick onward.
- R8: Queues are independent. Traffic to, or programming of, one queue leaves every other queue's level and counters unchanged.
- R9: Field 4 counts the admitted frames of a queue and field 5 counts its dropped frames, each one per frame.
- R10: The register address is the queue number times 8 plus the field code. Field 3 reads the current level. Fields 3, 4 and 5 are read-only, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat valid |
| inSof | input | 1 | First beat of a frame |
| inEof | input | 1 | Last beat of a frame |
| inQueue | input | QW | Target queue of the frame |
| inLen | input | LEN_W | Frame length in bytes, sampled with inSof |
| inData | input | DATA_W | Beat payload |
| outValid | output | 1 | Forwarded beat valid |
| outSof | output | 1 | Forwarded first beat |
| outEof | output | 1 | Forwarded last beat |
| outQueue | output | QW | Queue of the forwarded beat |
| outData | output | DATA_W | Forwarded payload |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | QW+3 | Queue number times 8 plus field code |
| regWrData | input | TOK_W | Register write data |
| regRdData | output | RD_W | Register read data |

## Verification
The bucket assertions assume that frames do not interleave, and that every frame opens with an `inSof` beat carrying its length before any other of its beats. Under that assumption a level is charged only by a length it already covers. The bench sends one frame at a time, always starting with a first beat, and does not retune a queue while one of its frames is in flight. It fills buckets by programming a large fill and then a zero fill, so that later levels follow from frame lengths alone. Refill is measured over windows whose length is an exact multiple of the tick period, so the result does not depend on the tick phase.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;
  localparam int unsigned QIX_W = 4;

  typedef enum logic [2:0] {
    FLD_CTRL  = 3'd0,
    FLD_FILL  = 3'd1,
    FLD_DEPTH = 3'd2,
    FLD_LEVEL = 3'd3,
    FLD_PASS  = 3'd4,
    FLD_DROP  = 3'd5
  } fieldE;

  typedef struct packed {
    logic             tick;
    logic             charge;
    logic             passStb;
    logic             dropStb;
    logic             fwdBeat;
    logic [QIX_W-1:0] frameQ;
    logic             cfgEnWr;
    logic             cfgFillWr;
    logic             cfgDepthWr;
    logic [QIX_W-1:0] cfgQ;
  } strobeT;
endpackage

// File: rtl/rxpol_bucket.sv
module rxpol_bucket #(
  parameter int unsigned LEN_W = 12,
  parameter int unsigned TOK_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             charge,
  input  logic             passHit,
  input  logic             dropHit,
  input  logic             enWr,
  input  logic             fillWr,
  input  logic             depthWr,
  input  logic [TOK_W-1:0] wrData,
  input  logic [LEN_W-1:0] chargeLen,
  output logic             enable,
  output logic [TOK_W-1:0] fill,
  output logic [TOK_W-1:0] depth,
  output logic [TOK_W-1:0] level,
  output logic [CNT_W-1:0] passCnt,
  output logic [CNT_W-1:0] dropCnt
);
  localparam int unsigned SUM_W = TOK_W + 1;

  logic [TOK_W-1:0] afterSub;
  logic [SUM_W-1:0] refillSum;
  logic [TOK_W-1:0] limit;
  logic [TOK_W-1:0] levelNext;

  always_comb begin
    afterSub  = charge ? level - TOK_W'(chargeLen) : level;
    refillSum = {1'b0, afterSub} + (tick ? {1'b0, fill} : {SUM_W{1'b0}});
    limit     = depthWr ? wrData : depth;
    levelNext = (refillSum > {1'b0, limit}) ? limit : refillSum[TOK_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= 1'b0;
      fill    <= '0;
      depth   <= '0;
      level   <= '0;
      passCnt <= '0;
      dropCnt <= '0;
    end else begin
      level <= levelNext;
      if (enWr)    enable  <= wrData[0];
      if (fillWr)  fill    <= wrData;
      if (depthWr) depth   <= wrData;
      if (passHit) passCnt <= passCnt + 1'b1;
      if (dropHit) dropCnt <= dropCnt + 1'b1;
    end
  end

  AST_LEVEL_CAPPED: assert property (@(posedge clk) disable iff (!rstN)
    level <= depth);  // R3
  AST_CHARGE_COVERED: assert property (@(posedge clk) disable iff (!rstN)
    charge |-> TOK_W'(chargeLen) <= level);  // R4
  AST_CHARGE_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (charge && !tick && !depthWr) |=> level == $past(level) - TOK_W'($past(chargeLen)));  // R4
  AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (dropHit && !tick && !depthWr) |=> level == $past(level));  // R5
  AST_REFILL_NO_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !charge && !depthWr) |=> level >= $past(level));  // R6
endmodule

// File: rtl/rxpol_ctrl.sv
module rxpol_ctrl
  import rxpol_pkg::*;
#(
  parameter int unsigned NUM_Q       = 4,
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned TOK_W       = 16,
  parameter int unsigned TICK_PERIOD = 8,
  parameter int unsigned QW          = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic                        inSof,
  input  logic [QW-1:0]               inQueue,
  input  logic [LEN_W-1:0]            inLen,
  input  logic                        regWrEn,
  input  logic [2:0]                  regField,
  input  logic [QW-1:0]               regQ,
  input  logic [NUM_Q-1:0]            enVec,
  input  logic [NUM_Q-1:0][TOK_W-1:0] tokVec,
  output strobeT                      stb
);
  localparam int unsigned TCW   = (TICK_PERIOD > 2) ? $clog2(TICK_PERIOD) : 1;
  localparam int unsigned CMP_W = (LEN_W > TOK_W) ? LEN_W : TOK_W;

  logic [TCW-1:0]   tickCnt;
  logic             tickNow;
  logic             passFlag;
  logic             sofBeat;
  logic             fits;
  logic             admit;
  logic             qEn;
  logic [TOK_W-1:0] qTok;

  assign tickNow = (tickCnt == TCW'(TICK_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rstN) tickCnt <= '0;
    else       tickCnt <= tickNow ? '0 : tickCnt + 1'b1;
  end

  always_comb begin
    qTok    = tokVec[inQueue];
    qEn     = enVec[inQueue];
    sofBeat = inValid & inSof;
    fits    = CMP_W'(qTok) >= CMP_W'(inLen);
    admit   = !qEn || fits;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        passFlag <= 1'b0;
    else if (sofBeat) passFlag <= admit;
  end

  always_comb begin
    stb            = '0;
    stb.tick       = tickNow;
    stb.charge     = sofBeat & admit & qEn;
    stb.passStb    = sofBeat & admit;
    stb.dropStb    = sofBeat & !admit;
    stb.fwdBeat    = sofBeat ? admit : (inValid & passFlag);
    stb.frameQ     = QIX_W'(inQueue);
    stb.cfgEnWr    = regWrEn && (regField == FLD_CTRL);
    stb.cfgFillWr  = regWrEn && (regField == FLD_FILL);
    stb.cfgDepthWr = regWrEn && (regField == FLD_DEPTH);
    stb.cfgQ       = QIX_W'(regQ);
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    stb.tick |=> !stb.tick);  // R6
  AST_DISABLED_ADMITS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof && !enVec[inQueue]) |-> (stb.passStb && !stb.charge));  // R2
endmodule

// File: rtl/rxpol_dp.sv
module rxpol_dp
  import rxpol_pkg::*;
#(
  parameter int unsigned NUM_Q  = 4,
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned TOK_W  = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned QW     = 2,
  parameter int unsigned RD_W   = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobeT                      stb,
  input  logic                        inSof,
  input  logic                        inEof,
  input  logic [QW-1:0]               inQueue,
  input  logic [LEN_W-1:0]            inLen,
  input  logic [DATA_W-1:0]           inData,
  input  logic [TOK_W-1:0]            regWrData,
  input  logic [2:0]                  regField,
  input  logic [QW-1:0]               regQ,
  output logic [NUM_Q-1:0]            enVec,
  output logic [NUM_Q-1:0][TOK_W-1:0] tokVec,
  output logic [RD_W-1:0]             regRdData,
  output logic                        outValid,
  output logic                        outSof,
  output logic                        outEof,
  output logic [QW-1:0]               outQueue,
  output logic [DATA_W-1:0]           outData
);
  logic [TOK_W-1:0] fillA  [NUM_Q];
  logic [TOK_W-1:0] depthA [NUM_Q];
  logic [CNT_W-1:0] passA  [NUM_Q];
  logic [CNT_W-1:0] dropA  [NUM_Q];

  for (genvar i = 0; i < NUM_Q; i++) begin : gBucket
    logic frameHit;
    logic cfgHit;
    assign frameHit = (stb.frameQ == QIX_W'(i));
    assign cfgHit   = (stb.cfgQ == QIX_W'(i));

    rxpol_bucket #(
      .LEN_W(LEN_W),
      .TOK_W(TOK_W),
      .CNT_W(CNT_W)
    ) uBucket (
      .clk      (clk),
      .rstN     (rstN),
      .tick     (stb.tick),
      .charge   (stb.charge & frameHit),
      .passHit  (stb.passStb & frameHit),
      .dropHit  (stb.dropStb & frameHit),
      .enWr     (stb.cfgEnWr & cfgHit),
      .fillWr   (stb.cfgFillWr & cfgHit),
      .depthWr  (stb.cfgDepthWr & cfgHit),
      .wrData   (regWrData),
      .chargeLen(inLen),
      .enable   (enVec[i]),
      .fill     (fillA[i]),
      .depth    (depthA[i]),
      .level    (tokVec[i]),
      .passCnt  (passA[i]),
      .dropCnt  (dropA[i])
    );
  end

  always_comb begin
    case (regField)
      FLD_CTRL:  regRdData = RD_W'(enVec[regQ]);
      FLD_FILL:  regRdData = RD_W'(fillA[regQ]);
      FLD_DEPTH: regRdData = RD_W'(depthA[regQ]);
      FLD_LEVEL: regRdData = RD_W'(tokVec[regQ]);
      FLD_PASS:  regRdData = RD_W'(passA[regQ]);
      FLD_DROP:  regRdData = RD_W'(dropA[regQ]);
      default:   regRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEof   <= 1'b0;
      outQueue <= '0;
      outData  <= '0;
    end else begin
      outValid <= stb.fwdBeat;
      if (stb.fwdBeat) begin
        outSof   <= inSof;
        outEof   <= inEof;
        outQueue <= inQueue;
        outData  <= inData;
      end
    end
  end

  AST_DROPPED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    stb.dropStb |=> !outValid);  // R5
endmodule

// File: rtl/rx_queue_policer.sv
module rx_queue_policer
  import rxpol_pkg::*;
#(
  parameter int unsigned NUM_Q       = 4,
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned TOK_W       = 16,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TICK_PERIOD = 8,
  parameter int unsigned QW          = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  parameter int unsigned RD_W        = (TOK_W > CNT_W) ? TOK_W : CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [QW-1:0]     inQueue,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic              outSof,
  output logic              outEof,
  output logic [QW-1:0]     outQueue,
  output logic [DATA_W-1:0] outData,
  input  logic              regWrEn,
  input  logic [QW+2:0]     regAddr,
  input  logic [TOK_W-1:0]  regWrData,
  output logic [RD_W-1:0]   regRdData
);
  strobeT                      stb;
  logic [NUM_Q-1:0]            enVec;
  logic [NUM_Q-1:0][TOK_W-1:0] tokVec;
  logic [2:0]                  regField;
  logic [QW-1:0]               regQ;

  assign regField = regAddr[2:0];
  assign regQ     = regAddr[QW+2:3];

  rxpol_ctrl #(
    .NUM_Q(NUM_Q), .LEN_W(LEN_W), .TOK_W(TOK_W),
    .TICK_PERIOD(TICK_PERIOD), .QW(QW)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inSof(inSof), .inQueue(inQueue), .inLen(inLen),
    .regWrEn(regWrEn), .regField(regField), .regQ(regQ),
    .enVec(enVec), .tokVec(tokVec), .stb(stb)
  );

  rxpol_dp #(
    .NUM_Q(NUM_Q), .LEN_W(LEN_W), .TOK_W(TOK_W), .CNT_W(CNT_W),
    .DATA_W(DATA_W), .QW(QW), .RD_W(RD_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inSof(inSof), .inEof(inEof), .inQueue(inQueue), .inLen(inLen), .inData(inData),
    .regWrData(regWrData), .regField(regField), .regQ(regQ),
    .enVec(enVec), .tokVec(tokVec), .regRdData(regRdData),
    .outValid(outValid), .outSof(outSof), .outEof(outEof),
    .outQueue(outQueue), .outData(outData)
  );
endmodule

// File: tb/rx_queue_policer_test.sv
module rx_queue_policer_test;
  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [1:0]  inQueue = '0;
  logic [11:0] inLen = '0;
  logic [31:0] inData = '0;
  logic        outValid, outSof, outEof;
  logic [1:0]  outQueue;
  logic [31:0] outData;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;

  int total = 0, bad = 0;
  int outBeats = 0, expBeats = 0;
  int outFrames[4];
  int expFrames[4];
  logic [31:0] outSum = '0, expSum = '0;

  always #10 clk = ~clk;

  rx_queue_policer uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inQueue(inQueue), .inLen(inLen), .inData(inData),
    .outValid(outValid), .outSof(outSof), .outEof(outEof),
    .outQueue(outQueue), .outData(outData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  always @(negedge clk) begin
    if (outValid) begin
      outBeats++;
      outSum = outSum + outData;
      if (outSof) outFrames[outQueue]++;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int q, int f, int d);
    regWrEn = 1'b1; regAddr = {2'(q), 3'(f)}; regWrData = 16'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(int q, int f, output int v);
    regAddr = {2'(q), 3'(f)};
    #1;
    v = int'(regRdData);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(int q, int len, int beats, bit expPass);
    for (int b = 0; b < beats; b++) begin
      inValid = 1'b1; inSof = (b == 0); inEof = (b == beats - 1);
      inQueue = 2'(q); inLen = 12'(len);
      inData = 32'(q * 65536 + len * 16 + b + 1);
      if (expPass) begin
        expBeats++;
        expSum = expSum + inData;
      end
      @(negedge clk);
    end
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    if (expPass) expFrames[q]++;
    idle(1);
    #1;
  endtask

  task automatic fillTo(int q, int d);
    wr(q, 2, d);
    wr(q, 1, 65535);
    idle(2 * P);
    wr(q, 1, 0);
  endtask

  task automatic checkStream(string req);
    check({req, " beats"}, outBeats, expBeats);
    check({req, " data sum"}, int'(outSum), int'(expSum));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    for (int i = 0; i < 4; i++) begin outFrames[i] = 0; expFrames[i] = 0; end
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 / R10: every field of every queue reads zero after reset
    for (int q = 0; q < 4; q++)
      for (int f = 0; f < 6; f++) begin
        rd(q, f, v);
        check("R1 reset register", v, 0);
      end
    check("R1 outValid idle", int'(outValid), 0);

    // R2: disabled queue forwards everything, level uncharged
    frame(0, 100, 4, 1'b1);
    frame(0, 2000, 1, 1'b1);
    frame(0, 7, 3, 1'b1);
    checkStream("R2");
    check("R2 frames q0", outFrames[0], 3);
    rd(0, 3, v); check("R2 level not charged", v, 0);
    rd(0, 4, v); check("R2 pass count", v, 3);

    // R3: fill saturates at depth
    wr(1, 0, 1);
    fillTo(1, 100);
    rd(1, 3, v); check("R3 level capped at depth", v, 100);

    // R4: admit and charge
    frame(1, 60, 3, 1'b1);
    rd(1, 3, v); check("R4 level after charge", v, 40);
    checkStream("R4");
    check("R4 frames q1", outFrames[1], 1);
    // R5: uncovered frame dropped whole, no tokens
    frame(1, 50, 5, 1'b0);
    rd(1, 3, v); check("R5 level unchanged by drop", v, 40);
    checkStream("R5");
    // R4: exact cover boundary
    frame(1, 40, 2, 1'b1);
    rd(1, 3, v); check("R4 exact cover empties bucket", v, 0);
    frame(1, 1, 2, 1'b0);
    checkStream("R5 empty bucket");
    rd(1, 5, v); check("R9 drop count q1", v, 2);

    // R6: 3 ticks of fill 7
    wr(1, 1, 7);
    idle(3 * P - 1);
    wr(1, 1, 0);
    rd(1, 3, v); check("R6 refill over 3 ticks", v, 21);

    // R7: depth clamp, depth raise adds nothing, fill from next tick
    wr(1, 2, 10);
    rd(1, 3, v); check("R7 level clamped by depth write", v, 10);
    wr(1, 2, 100);
    rd(1, 3, v); check("R7 depth raise adds no tokens", v, 10);
    wr(1, 1, 5);
    idle(P - 1);
    wr(1, 1, 0);
    rd(1, 3, v); check("R7 new fill applied per tick", v, 15);

    // R8: independence
    wr(2, 0, 1);
    frame(2, 1, 1, 1'b0);
    frame(3, 30, 2, 1'b1);
    rd(2, 5, v); check("R8 drop count q2", v, 1);
    rd(3, 4, v); check("R8 pass count q3", v, 1);
    rd(1, 3, v); check("R8 q1 level untouched", v, 15);
    rd(1, 4, v); check("R8 q1 pass count untouched", v, 2);
    rd(0, 4, v); check("R8 q0 pass count untouched", v, 3);
    checkStream("R8");

    // R4 / R5 sweep over frame lengths around a depth of 64
    for (int len = 0; len <= 70; len++) begin
      bit pass;
      int lvl;
      pass = (len <= 64);
      fillTo(1, 64);
      frame(1, len, 2, pass);
      rd(1, 3, lvl);
      check(pass ? "R4 sweep level" : "R5 sweep level", lvl, pass ? 64 - len : 64);
      check(pass ? "R4 sweep beats" : "R5 sweep beats", outBeats, expBeats);
    end
    checkStream("R4 sweep");
    for (int q = 0; q < 4; q++) check("R4 frames per queue", outFrames[q], expFrames[q]);
    rd(1, 4, v); check("R9 pass count q1", v, 67);
    rd(1, 5, v); check("R9 drop count q1", v, 8);
    rd(1, 0, v); check("R10 enable readback", v, 1);
    rd(1, 2, v); check("R10 depth readback", v, 64);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule